// File: doc/BRIEF.md
# Processor Fault Exception Controller

This block sits beside a 32-bit processor core and turns the core's fault and trap conditions into exception requests. It checks every access for misalignment, holds back the faults that must wait (a released operand write, a taken branch to an odd target), and collects bus errors, divide-by-zero and trap requests together with trace events. It then presents exactly one vector number at a time to the core. The core clears each request with a one-cycle acknowledge pulse.

The block also watches the core's processing state. A fault that arrives while the core is already handling a critical exception cannot be serviced safely. Such a fault latches a halt, and the halt drops only through the synchronous reset. Stacking, instruction execution and memory stay in the core.

Top module: `fault_exc_ctrl`

## Requirements
- R1: An operand access (`acc_fetch`=0) at an odd address with `acc_size` word (1) or long (2) requests vector 3 one cycle later. A byte access (`acc_size`=0) or an even address requests nothing.
- R2: An instruction fetch (`acc_fetch`=1) at an odd address requests vector 3, whatever the size field says.
- R3: `bus_err` requests vector 2 when `proc_state` is running (0) or other exception (5). When `proc_state` is bus-error exception (1), address-error exception (2), reset exception (3) or return-stack reload (4), `bus_err` sets `halted` instead.
- R4: An address fault in `proc_state` 1, 2 or 3 sets `halted`. An address fault during return-stack reload (4) is an ordinary vector 3 request.
- R5: `halted` stays high until `rst_n` is low at a clock edge. While it is high, `exc_req` stays low and new faults and traps are discarded.
- R6: A resolved taken branch (`br_valid`, `br_taken`) to an odd `br_target` requests vector 3 only in the cycle after `pc_load`. A branch that is not taken requests nothing, even when `pc_load` follows.
- R7: An odd misaligned operand access flagged `acc_released` is held back. It requests vector 3 after the next `insn_bound` or the next non-released access, whichever comes first.
- R8: If `trace_en` is high at `insn_start`, `insn_bound` ends that instruction with a trace request (vector 9). If the same instruction raised `trap_req`, vector 32+`trap_num` is issued first and vector 9 follows after its acknowledge.
- R9: `div_zero` requests vector 5.
- R10: `exc_req` with `exc_vec` holds steady until `exc_ack`. Only one request is open at a time. Pending events are issued in the order bus error (2), address error (3), divide-by-zero (5), trap, trace (9). The next pending request appears in the cycle after the acknowledge.
- R11: After reset `exc_req` and `halted` are low and `exc_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_state | input | 3 | Core processing state: 0 run, 1 bus-error exc, 2 address-error exc, 3 reset exc, 4 return-stack reload, 5 other exc |
| acc_valid | input | 1 | An access is attempted this cycle |
| acc_fetch | input | 1 | The access is an instruction fetch |
| acc_released | input | 1 | The access is a released operand write |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| acc_addr | input | 32 | Access address |
| bus_err | input | 1 | Bus error strobe |
| br_valid | input | 1 | Branch resolved this cycle |
| br_taken | input | 1 | The resolved branch is taken |
| br_target | input | 32 | Branch target address |
| pc_load | input | 1 | The core updates its PC this cycle |
| trap_req | input | 1 | Trap instruction request |
| trap_num | input | 4 | Trap number n, vector 32+n |
| div_zero | input | 1 | Divide with zero divisor |
| trace_en | input | 1 | Trace enable bit |
| insn_start | input | 1 | An instruction begins |
| insn_bound | input | 1 | An instruction completes |
| exc_ack | input | 1 | Core accepts the open request |
| exc_req | output | 1 | Exception request |
| exc_vec | output | 8 | Vector number of the request |
| halted | output | 1 | Core halted by a double fault |

## Verification
The hardest situations to reach from the ports are the ones where two rules meet: a trap and a trace from the same instruction, and a bus error arriving together with a divide-by-zero while an earlier request is still unacknowledged. The stimulus raises those events in the same cycle and withholds `exc_ack` for several cycles, so it can observe both ordering and holding. Double faults are reached by holding `proc_state` at each critical code while faults are injected. Further faults and a reset then follow, to show that the halt is sticky and that it ends.

// File: rtl/fexc_pkg.sv
// Shared encodings for the fault exception controller.
// Assumes an 8-bit vector field and the proc_state codes listed in the brief.
package fexc_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        PS_RUN   = 3'd0,
        PS_BERR  = 3'd1,
        PS_AERR  = 3'd2,
        PS_RESET = 3'd3,
        PS_RTE   = 3'd4,
        PS_OTHER = 3'd5
    } pstate_e;

    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] VEC_BERR      = 8'd2;
    localparam logic [VEC_W-1:0] VEC_AERR      = 8'd3;
    localparam logic [VEC_W-1:0] VEC_DZ        = 8'd5;
    localparam logic [VEC_W-1:0] VEC_TRACE     = 8'd9;
    localparam logic [VEC_W-1:0] VEC_TRAP_BASE = 8'd32;

    // Pending-source index; a lower index wins arbitration.
    localparam int SRC_BERR  = 0;
    localparam int SRC_AERR  = 1;
    localparam int SRC_DZ    = 2;
    localparam int SRC_TRAP  = 3;
    localparam int SRC_TRACE = 4;
    localparam int NSRC      = 5;
endpackage

// File: rtl/fexc_align_check.sv
// Misalignment detector with two deferral slots.
// Raises a one-cycle aerr_evt for an odd fetch or odd word/long access.
// A released write holds its fault until the next boundary or access.
// An odd taken branch holds its fault until the PC is loaded.
// Assumes pc_load never arrives earlier than the branch it belongs to.
module fexc_align_check
    import fexc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kill,
    input  logic          acc_valid,
    input  logic          acc_fetch,
    input  logic          acc_released,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] acc_addr,
    input  logic          br_valid,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic          pc_load,
    input  logic          insn_bound,
    output logic          aerr_evt
);
    logic dfr_q, dfr_nxt, br_pend_q, br_pend_nxt;
    logic odd_acc, imm_fault, new_dfr, dfr_fire, br_odd, br_fire;

    // Classify this cycle's access and branch, and decide which faults fire now.
    always_comb begin
        odd_acc     = acc_valid && acc_addr[0] &&
                      (acc_fetch || acc_size != SZ_BYTE);
        new_dfr     = odd_acc && acc_released && !acc_fetch;
        imm_fault   = odd_acc && !new_dfr;
        dfr_fire    = dfr_q && (insn_bound || (acc_valid && !acc_released));
        dfr_nxt     = (dfr_q && !dfr_fire) || new_dfr;
        br_odd      = br_valid && br_taken && br_target[0];
        br_fire     = pc_load && (br_pend_q || br_odd);
        br_pend_nxt = pc_load ? 1'b0 : (br_valid ? br_odd : br_pend_q);
        aerr_evt    = imm_fault || dfr_fire || br_fire;
    end

    // Hold the deferred released-write and odd-branch faults.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            dfr_q     <= 1'b0;
            br_pend_q <= 1'b0;
        end else begin
            dfr_q     <= dfr_nxt;
            br_pend_q <= br_pend_nxt;
        end
    end

    // R1: a byte operand access with nothing deferred raises no fault
    a_r1_byte_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_fetch && acc_size == SZ_BYTE && !dfr_q && !pc_load)
        |-> !aerr_evt);

    // R6: a PC load always consumes any pending odd-branch fault
    a_r6_pcload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !br_pend_q);
endmodule

// File: rtl/fexc_double_fault.sv
// Double-fault detector and halt latch.
// A bus error in a critical state (bus/address/reset exception or stack reload)
// or an address fault in bus/address/reset exception sets the halt.
// Assumes proc_state is valid in the same cycle as the fault strobe.
module fexc_double_fault
    import fexc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] proc_state,
    input  logic       bus_err,
    input  logic       aerr_evt,
    output logic       halt_set,
    output logic       halted
);
    logic halted_q, berr_crit, aerr_crit;

    // Decide whether this cycle's fault hits a critical processing state.
    always_comb begin
        berr_crit = (proc_state == PS_BERR) || (proc_state == PS_AERR) ||
                    (proc_state == PS_RESET) || (proc_state == PS_RTE);
        aerr_crit = (proc_state == PS_BERR) || (proc_state == PS_AERR) ||
                    (proc_state == PS_RESET);
        halt_set  = !halted_q && ((bus_err && berr_crit) || (aerr_evt && aerr_crit));
        halted    = halted_q;
    end

    // Latch the halt; only reset releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) halted_q <= 1'b0;
        else        halted_q <= halted_q || halt_set;
    end

    // R5: the halt is sticky while reset is inactive
    a_r5_sticky_halt: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> halted_q);

    // R3: a bus error in the stack-reload state always halts
    a_r3_berr_reload_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && proc_state == PS_RTE) |=> halted_q);
endmodule

// File: rtl/fexc_arbiter.sv
// Pending-event store, trace tracker and single-request handshake.
// Collects bus, address, divide, trap and trace events and issues the
// highest-priority one as a held request until acknowledged.
// Assumes trap and trace come from the instruction between insn_start and insn_bound.
module fexc_arbiter
    import fexc_pkg::*;
#(
    parameter int TRAPW = 4,
    parameter int VW    = VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             berr_evt,
    input  logic             aerr_evt,
    input  logic             dz_evt,
    input  logic             trap_evt,
    input  logic [TRAPW-1:0] trap_num,
    input  logic             trace_en,
    input  logic             insn_start,
    input  logic             insn_bound,
    input  logic             exc_ack,
    output logic             exc_req,
    output logic [VW-1:0]    exc_vec
);
    logic [NSRC-1:0]  pend_q, pend_nxt, evt, pick;
    logic [TRAPW-1:0] tnum_q, tnum_nxt;
    logic             armed_q, armed_now, trace_evt, req_q, load;
    logic [VW-1:0]    vec_q, sel_vec;

    // Track trace for the instruction in flight and merge new events.
    always_comb begin
        armed_now = armed_q || (insn_start && trace_en);
        trace_evt = insn_bound && armed_now;
        evt       = '0;
        evt[SRC_BERR]  = berr_evt;
        evt[SRC_AERR]  = aerr_evt;
        evt[SRC_DZ]    = dz_evt;
        evt[SRC_TRAP]  = trap_evt;
        evt[SRC_TRACE] = trace_evt;
        pend_nxt  = pend_q | evt;
        tnum_nxt  = trap_evt ? trap_num : tnum_q;
        pick      = pend_nxt & (~pend_nxt + NSRC'(1));
        load      = (!req_q || exc_ack) && (|pend_nxt);
    end

    // Map the chosen source to its vector number.
    always_comb begin
        sel_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pick[i]) begin
                case (i)
                    SRC_BERR: sel_vec = VEC_BERR;
                    SRC_AERR: sel_vec = VEC_AERR;
                    SRC_DZ:   sel_vec = VEC_DZ;
                    SRC_TRAP: sel_vec = VEC_TRAP_BASE + VW'(tnum_nxt);
                    default:  sel_vec = VEC_TRACE;
                endcase
            end
        end
    end

    // Store pending events and run the request/acknowledge handshake.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            pend_q  <= '0;
            tnum_q  <= '0;
            armed_q <= 1'b0;
            req_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            armed_q <= armed_now && !insn_bound;
            tnum_q  <= tnum_nxt;
            if (load) begin
                req_q  <= 1'b1;
                vec_q  <= sel_vec;
                pend_q <= pend_nxt & ~pick;
            end else begin
                pend_q <= pend_nxt;
                if (exc_ack) req_q <= 1'b0;
            end
        end
    end

    assign exc_req = req_q;
    assign exc_vec = vec_q;

    // R10: an open request holds its vector until acknowledged
    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !exc_ack && !kill) |=> (exc_req && $stable(exc_vec)));

    // R5: a halt event silences the request output
    a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !exc_req);
endmodule

// File: rtl/fault_exc_ctrl.sv
// Top of the processor fault exception controller.
// Ties the alignment checker, the double-fault latch and the arbiter.
// Every fault or trap is suppressed once a halt is latched or being set.
// Assumes all inputs are synchronous to clk and single-cycle strobes.
module fault_exc_ctrl
    import fexc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int TRAPW = 4,
    parameter int VW    = VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       proc_state,
    input  logic             acc_valid,
    input  logic             acc_fetch,
    input  logic             acc_released,
    input  logic [1:0]       acc_size,
    input  logic [AW-1:0]    acc_addr,
    input  logic             bus_err,
    input  logic             br_valid,
    input  logic             br_taken,
    input  logic [AW-1:0]    br_target,
    input  logic             pc_load,
    input  logic             trap_req,
    input  logic [TRAPW-1:0] trap_num,
    input  logic             div_zero,
    input  logic             trace_en,
    input  logic             insn_start,
    input  logic             insn_bound,
    input  logic             exc_ack,
    output logic             exc_req,
    output logic [VW-1:0]    exc_vec,
    output logic             halted
);
    logic aerr_evt, halt_set, halted_q, kill;

    // Any latched or incoming halt flushes the other units.
    assign kill   = halted_q || halt_set;
    assign halted = halted_q;

    fexc_align_check #(.AW(AW)) u_align (
        .clk(clk), .rst_n(rst_n), .kill(kill),
        .acc_valid(acc_valid), .acc_fetch(acc_fetch), .acc_released(acc_released),
        .acc_size(acc_size), .acc_addr(acc_addr),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .pc_load(pc_load), .insn_bound(insn_bound), .aerr_evt(aerr_evt)
    );

    fexc_double_fault u_dflt (
        .clk(clk), .rst_n(rst_n), .proc_state(proc_state),
        .bus_err(bus_err), .aerr_evt(aerr_evt),
        .halt_set(halt_set), .halted(halted_q)
    );

    fexc_arbiter #(.TRAPW(TRAPW), .VW(VW)) u_arb (
        .clk(clk), .rst_n(rst_n), .kill(kill),
        .berr_evt(bus_err), .aerr_evt(aerr_evt), .dz_evt(div_zero),
        .trap_evt(trap_req), .trap_num(trap_num),
        .trace_en(trace_en), .insn_start(insn_start), .insn_bound(insn_bound),
        .exc_ack(exc_ack), .exc_req(exc_req), .exc_vec(exc_vec)
    );

    // R10: a request always carries one of the defined vector numbers
    a_r10_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (exc_vec == VEC_BERR || exc_vec == VEC_AERR ||
                     exc_vec == VEC_DZ   || exc_vec == VEC_TRACE ||
                     (exc_vec >= VEC_TRAP_BASE &&
                      exc_vec < VEC_TRAP_BASE + VW'(1 << TRAPW))));

    // R5: no request is visible while halted
    a_r5_no_req_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !exc_req);
endmodule

// File: tb/sim_fault_exc_ctrl.sv
module sim_fault_exc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  proc_state;
    logic        acc_valid, acc_fetch, acc_released;
    logic [1:0]  acc_size;
    logic [31:0] acc_addr;
    logic        bus_err, br_valid, br_taken;
    logic [31:0] br_target;
    logic        pc_load, trap_req;
    logic [3:0]  trap_num;
    logic        div_zero, trace_en, insn_start, insn_bound, exc_ack;
    logic        exc_req, halted;
    logic [7:0]  exc_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fault_exc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .proc_state(proc_state),
        .acc_valid(acc_valid), .acc_fetch(acc_fetch), .acc_released(acc_released),
        .acc_size(acc_size), .acc_addr(acc_addr), .bus_err(bus_err),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .pc_load(pc_load), .trap_req(trap_req), .trap_num(trap_num),
        .div_zero(div_zero), .trace_en(trace_en), .insn_start(insn_start),
        .insn_bound(insn_bound), .exc_ack(exc_ack),
        .exc_req(exc_req), .exc_vec(exc_vec), .halted(halted)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_fetch = 0; acc_released = 0; acc_size = 0; acc_addr = 0;
        bus_err = 0; br_valid = 0; br_taken = 0; br_target = 0; pc_load = 0;
        trap_req = 0; trap_num = 0; div_zero = 0; insn_start = 0; insn_bound = 0;
        exc_ack = 0;
    endtask

    // Apply whatever inputs the caller set for one edge, then clear them.
    task automatic pulse();
        @(negedge clk);
        idle();
    endtask

    task automatic expect_vec(string tag, int v);
        check({tag, " req"}, exc_req, 1);
        check({tag, " vec"}, exc_vec, v);
        exc_ack = 1;
        @(negedge clk);
        exc_ack = 0;
    endtask

    task automatic expect_none(string tag);
        check({tag, " no req"}, exc_req, 0);
    endtask

    task automatic do_reset();
        idle(); proc_state = 3'd0; trace_en = 0;
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic access(bit fetch, bit rel, int sz, int addr);
        acc_valid = 1; acc_fetch = fetch; acc_released = rel;
        acc_size = 2'(sz); acc_addr = 32'(addr);
        pulse();
    endtask

    task automatic t_reset();
        do_reset();
        check("R11 req", exc_req, 0);
        check("R11 halted", halted, 0);
        check("R11 vec", exc_vec, 0);
    endtask

    task automatic t_align();
        access(0, 0, 1, 'h1001); expect_vec("R1 odd word", 3);
        access(0, 0, 2, 'h2003); expect_vec("R1 odd long", 3);
        access(0, 0, 0, 'h1001); expect_none("R1 odd byte");
        access(0, 0, 2, 'h1002); expect_none("R1 even long");
        access(1, 0, 0, 'h4005); expect_vec("R2 odd fetch byte field", 3);
        access(1, 0, 1, 'h4006); expect_none("R2 even fetch");
    endtask

    task automatic t_div();
        div_zero = 1; pulse(); expect_vec("R9 divide zero", 5);
        expect_none("R9 after ack");
    endtask

    task automatic t_trace();
        trace_en = 1; insn_start = 1; trap_req = 1; trap_num = 4'd7; insn_bound = 1;
        pulse();
        expect_vec("R8 trap first", 39);
        expect_vec("R8 trace second", 9);
        expect_none("R8 drained");
        insn_start = 1; pulse();
        expect_none("R8 no trace before boundary");
        insn_bound = 1; pulse();
        expect_vec("R8 trace at boundary", 9);
        trace_en = 0;
        insn_start = 1; insn_bound = 1; pulse();
        expect_none("R8 trace off");
    endtask

    task automatic t_branch();
        br_valid = 1; br_taken = 1; br_target = 32'h801; pulse();
        expect_none("R6 before pc load");
        @(negedge clk); expect_none("R6 still waiting");
        pc_load = 1; pulse();
        expect_vec("R6 odd taken", 3);
        br_valid = 1; br_taken = 0; br_target = 32'h901; pulse();
        pc_load = 1; pulse();
        expect_none("R6 not taken");
    endtask

    task automatic t_released();
        access(0, 1, 1, 'h3001); expect_none("R7 held");
        @(negedge clk); expect_none("R7 still held");
        insn_bound = 1; pulse(); expect_vec("R7 at boundary", 3);
        access(0, 1, 2, 'h3003); expect_none("R7 held again");
        access(0, 0, 1, 'h3000); expect_vec("R7 at next access", 3);
        expect_none("R7 drained");
    endtask

    task automatic t_priority();
        bus_err = 1; div_zero = 1; trap_req = 1; trap_num = 4'd2; pulse();
        check("R10 first", exc_vec, 2);
        repeat (3) @(negedge clk);
        check("R10 held req", exc_req, 1);
        check("R10 held vec", exc_vec, 2);
        exc_ack = 1; @(negedge clk); exc_ack = 0;
        expect_vec("R10 second", 5);
        expect_vec("R10 third", 34);
        expect_none("R10 empty");
    endtask

    task automatic t_berr();
        proc_state = 3'd0; bus_err = 1; pulse(); expect_vec("R3 berr running", 2);
        proc_state = 3'd5; bus_err = 1; pulse(); expect_vec("R3 berr other exc", 2);
        check("R3 not halted", halted, 0);
        proc_state = 3'd4; bus_err = 1; pulse();
        check("R3 halt in reload", halted, 1);
        expect_none("R3 halted");
        do_reset();
        proc_state = 3'd3; bus_err = 1; pulse();
        check("R3 halt in reset exc", halted, 1);
        do_reset();
    endtask

    task automatic t_aerr_double();
        proc_state = 3'd4; access(0, 0, 1, 'h51);
        expect_vec("R4 reload is ordinary", 3);
        check("R4 reload not halted", halted, 0);
        proc_state = 3'd2; access(0, 0, 1, 'h51);
        check("R4 halt in aerr exc", halted, 1);
        expect_none("R4 halted");
        proc_state = 3'd0;
    endtask

    task automatic t_halt_sticky();
        bus_err = 1; pulse(); expect_none("R5 berr ignored");
        div_zero = 1; pulse(); expect_none("R5 div ignored");
        repeat (4) @(negedge clk);
        check("R5 still halted", halted, 1);
        do_reset();
        check("R5 reset clears", halted, 0);
        div_zero = 1; pulse(); expect_vec("R5 live again", 5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; proc_state = 0; trace_en = 0; idle();
        t_reset();
        t_align();
        t_div();
        t_trace();
        t_branch();
        t_released();
        t_priority();
        t_berr();
        t_aerr_double();
        t_halt_sticky();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule